// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block derives the pixel timing for a display panel from a reference clock. A 32-bit configuration word carries a divisor that is split into two separate bit ranges, plus a bypass bit. The block joins the two ranges into one divisor code and adds two to get the divide ratio. It then produces two outputs: a one-cycle pixel enable pulse that the rest of the display pipeline can use as a clock enable, and a divided clock with a near-50% duty cycle for the panel pin.

Software picks the divisor and writes the configuration word at any time. A new setting never takes effect in the middle of an output period. It is picked up only when the current period ends, so the panel clock never shows a runt pulse. The bypass bit is the only way to get divide-by-one. While bypass is set, the divisor field is ignored and the panel clock follows the reference clock.

Top module: `pixclk_div_top`

## Requirements
- R1: While reset is asserted, and for two reference cycles after it is released (reset synchroniser), `pix_en` and `pix_clk` are both 0.
- R2: With bypass clear, the divide ratio N is the divisor code plus 2, and `pix_en` is high for exactly one reference cycle in every N cycles.
- R3: The divisor code is 10 bits wide. `cfg_word[31:27]` forms its upper five bits and `cfg_word[4:0]` its lower five. Bits 25:5 have no effect.
- R4: When bypass (`cfg_word[26]`) is set, `pix_en` is high on every reference cycle, whatever the divisor bits hold.
- R5: The largest ratio is reached with all ten divisor bits set: one `pix_en` pulse every 1025 cycles.
- R6: With bypass clear, `pix_clk` is high for floor(N/2) cycles, starting in the cycle after a `pix_en` pulse. It is low for the remaining ceil(N/2) cycles, so for odd N the high phase is one cycle shorter than the low phase.
- R7: A change to `cfg_word` takes effect only at the end of the current period. The period in progress finishes with the old ratio.
- R8: While bypass is in effect, `pix_clk` equals the reference clock. Entering and leaving bypass happens at a period boundary, without a shortened pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_ref_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_word | input | 32 | Divisor code fields and bypass bit |
| pix_en | output | 1 | One-cycle pixel enable pulse, once per output period |
| pix_clk | output | 1 | Divided panel clock, or the reference clock in bypass |

## Verification
A bad counter value or a stale active ratio shows up at once in `pix_en`. A bad period end moves the next pulse by at least one cycle, and a ratio latched at the wrong time stretches or shrinks the period in progress. Because a behavioural model is compared against both outputs on every reference cycle, a divergence is reported within one cycle of its first visible effect. The worst case is one full output period, up to 1025 cycles, when the fault only changes where the next wrap falls. Directed checks also measure period length, high-phase length and the timing of a mid-period reprogramming.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // Field layout of the configuration word
  localparam int CFG_W   = 32;
  localparam int LO_LSB  = 0;
  localparam int LO_W    = 5;
  localparam int HI_LSB  = 27;
  localparam int HI_W    = 5;
  localparam int BYP_BIT = 26;
  localparam int CODE_W  = LO_W + HI_W;
  // One extra bit so code + 2 fits
  localparam int RATIO_W = CODE_W + 1;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   byp;
    ratio_t ratio;
  } div_req_t;
endpackage

// File: rtl/pcd_rst_sync.sv
module pcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcd_field_unpack.sv
module pcd_field_unpack
  import pcd_pkg::*;
#(
  parameter int W_CFG = CFG_W
) (
  input  logic [W_CFG-1:0] cfg,
  output div_req_t         req
);
  logic [CODE_W-1:0] code;

  generate
    if (HI_W > 0) begin : g_split
      assign code = {cfg[HI_LSB +: HI_W], cfg[LO_LSB +: LO_W]};
    end else begin : g_single
      assign code = cfg[LO_LSB +: LO_W];
    end
  endgenerate

  always_comb begin
    req.byp = cfg[BYP_BIT];
    if (cfg[BYP_BIT]) req.ratio = ratio_t'(1);
    else              req.ratio = ratio_t'(code) + ratio_t'(2);
  end
endmodule

// File: rtl/pcd_div_core.sv
module pcd_div_core
  import pcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_req_t req,
  output logic     en_o,
  output logic     phase_o,
  output logic     byp_o
);
  ratio_t cnt_q, cnt_d;
  ratio_t div_q, div_d;
  logic   byp_q, byp_d;
  logic   en_q,  en_d;
  logic   ph_q,  ph_d;
  logic   wrap;

  // Next-state logic
  always_comb begin
    wrap = (cnt_q == div_q - ratio_t'(1));
    if (wrap) begin
      cnt_d = '0;
      div_d = req.ratio;
      byp_d = req.byp;
    end else begin
      cnt_d = cnt_q + ratio_t'(1);
      div_d = div_q;
      byp_d = byp_q;
    end
    en_d = (cnt_d == div_d - ratio_t'(1));
    ph_d = (cnt_d < (div_d >> 1));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= ratio_t'(1);
      byp_q <= 1'b0;
      en_q  <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      byp_q <= byp_d;
      en_q  <= en_d;
      ph_q  <= ph_d;
    end
  end

  assign en_o    = en_q;
  assign phase_o = ph_q;
  assign byp_o   = byp_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != div_q - ratio_t'(1)) |=> ($stable(div_q) && $stable(byp_q)));

  // R4
  byp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> en_q);

  // R6
  last_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !byp_q) |-> !ph_q);
endmodule

// File: rtl/pixclk_div_top.sv
module pixclk_div_top
  import pcd_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_ref_n,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             pix_en,
  output logic             pix_clk
);
  logic     rst_s_n;
  div_req_t req;
  logic     phase;
  logic     byp_act;

  pcd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk_ref),
    .arst_n (rst_ref_n),
    .srst_n (rst_s_n)
  );

  pcd_field_unpack #(.W_CFG(CFG_W)) u_unpack (
    .cfg (cfg_word),
    .req (req)
  );

  pcd_div_core u_core (
    .clk     (clk_ref),
    .rst_n   (rst_s_n),
    .req     (req),
    .en_o    (pix_en),
    .phase_o (phase),
    .byp_o   (byp_act)
  );

  // Select switches only at a rising reference edge that ends a period:
  // the divided phase is low then, and rises with the edge when leaving.
  assign pix_clk = byp_act ? clk_ref : phase;

  // R8
  byp_sel_chk: assert property (@(posedge clk_ref) disable iff (!rst_s_n)
    byp_act |-> pix_en);
endmodule

// File: tb/sim_pixclk_div_top.sv
module sim_pixclk_div_top;
  logic        clk_ref = 1'b0;
  logic        rst_ref_n = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        pix_en, pix_clk;

  int checks = 0;
  int errors = 0;

  pixclk_div_top u0 (
    .clk_ref   (clk_ref),
    .rst_ref_n (rst_ref_n),
    .cfg_word  (cfg_word),
    .pix_en    (pix_en),
    .pix_clk   (pix_clk)
  );

  always #5 clk_ref = ~clk_ref;

  // R3 layout: code[9:5] -> bits 31:27, code[4:0] -> bits 4:0, bypass bit 26
  function automatic logic [31:0] mk_cfg(input logic byp, input int code);
    logic [31:0] c;
    c        = '0;
    c[25:5]  = 21'h0A5A5;
    c[4:0]   = code[4:0];
    c[31:27] = code[9:5];
    c[26]    = byp;
    return c;
  endfunction

  function automatic int ratio_of(input logic [31:0] c);
    if (c[26]) return 1;
    return int'({c[31:27], c[4:0]}) + 2;
  endfunction

  // Behavioural reference model
  int   rel = 0;
  int   m_cnt = 0, m_div = 1;
  bit   m_byp = 0, e_en = 0, e_ph = 0;

  always @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      rel = 0; m_cnt = 0; m_div = 1; m_byp = 0; e_en = 0; e_ph = 0;
    end else if (rel < 2) begin
      rel = rel + 1;
    end else begin
      if (m_cnt == m_div - 1) begin
        m_cnt = 0;
        m_div = ratio_of(cfg_word);
        m_byp = cfg_word[26];
      end else begin
        m_cnt = m_cnt + 1;
      end
      e_en = (m_cnt == m_div - 1);
      e_ph = (m_cnt < m_div / 2);
    end
  end

  bit live = 0;
  always @(negedge clk_ref) begin
    if (live) begin
      checks++;
      if (pix_en !== e_en) begin
        errors++;
        $display("FAIL R2 pix_en model mismatch: actual=%b expected=%b t=%0t", pix_en, e_en, $time);
      end
      checks++;
      if (pix_clk !== (m_byp ? 1'b0 : e_ph)) begin
        errors++;
        $display("FAIL R6 pix_clk model mismatch: actual=%b expected=%b t=%0t",
                 pix_clk, (m_byp ? 1'b0 : e_ph), $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic period(output int p);
    do @(negedge clk_ref); while (!pix_en);
    p = 0;
    do begin @(negedge clk_ref); p++; end while (!pix_en);
  endtask

  task automatic high_len(input int n, output int h);
    do @(negedge clk_ref); while (!pix_en);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_ref);
      if (pix_clk) h++;
    end
  endtask

  task automatic settle_measure(input logic [31:0] c, output int p);
    int d;
    @(negedge clk_ref) cfg_word = c;
    period(d);
    period(d);
    period(p);
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int p, h, n;
    cfg_word = mk_cfg(0, 5);
    #1 rst_ref_n = 1'b0;
    repeat (4) @(negedge clk_ref);
    // R1 during reset
    chk("R1 pix_en in reset", int'(pix_en), 0);
    chk("R1 pix_clk in reset", int'(pix_clk), 0);
    live = 1;
    rst_ref_n = 1'b1;
    @(negedge clk_ref);
    chk("R1 pix_en after release", int'(pix_en), 0);
    @(negedge clk_ref);
    chk("R1 pix_clk after release", int'(pix_clk), 0);

    // R2 / R6: ratio 7, odd high phase
    settle_measure(mk_cfg(0, 5), p);
    chk("R2 period code 5", p, 7);
    high_len(7, h);
    chk("R6 high cycles ratio 7", h, 3);

    // R3: low field alone, high field alone
    settle_measure(mk_cfg(0, 1), p);
    chk("R3 low field bit0", p, 3);
    settle_measure(mk_cfg(0, 32), p);
    chk("R3 high field bit27", p, 34);
    high_len(34, h);
    chk("R6 high cycles ratio 34", h, 17);

    // R2 smallest divided ratio
    settle_measure(mk_cfg(0, 0), p);
    chk("R2 period code 0", p, 2);
    high_len(2, h);
    chk("R6 high cycles ratio 2", h, 1);

    // R4 / R8: bypass ignores divisor code
    settle_measure(mk_cfg(1, 123), p);
    chk("R4 bypass period", p, 1);
    @(posedge clk_ref); #2;
    chk("R8 pix_clk follows ref high", int'(pix_clk), 1);
    @(negedge clk_ref); #1;
    chk("R8 pix_clk follows ref low", int'(pix_clk), 0);

    // R8 leaving bypass
    settle_measure(mk_cfg(0, 3), p);
    chk("R8 period after bypass", p, 5);

    // R5 maximum ratio
    settle_measure(mk_cfg(0, 1023), p);
    chk("R5 max period", p, 1025);

    // R7: mid-period reprogramming
    settle_measure(mk_cfg(0, 38), p);
    chk("R7 base period", p, 40);
    repeat (10) @(negedge clk_ref);
    cfg_word = mk_cfg(0, 1);
    n = 0;
    do begin @(negedge clk_ref); n++; end while (!pix_en);
    chk("R7 old ratio completes", n, 30);
    period(p);
    chk("R7 new ratio after wrap", p, 3);

    repeat (5) @(negedge clk_ref);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule